// File: doc/BRIEF.md
# Aligned Conversion Result Buffer

This block sits behind an analog-to-digital converter. It takes each 10-bit conversion result and presents it on a byte-wide read port. The primary result register always holds the latest result. Software reads it as a high/low byte pair, with the value placed either toward the top of the 16-bit pair (left alignment) or toward the bottom (right alignment).

When buffered operation is enabled, each result is also written into the next slot of a ring of `NSLOT` slots. The last slot used is `last_slot`. End-of-conversion then fires only when the last slot of a round has been written, not after every result.

Each slot carries an unread bit. Writing into a slot whose previous result was never fully read raises a sticky overrun flag. A single shadow byte keeps the two reads of a pair coherent. The byte that alignment marks as first returns the live value and freezes the partner byte. The partner read then returns that frozen copy, even if a newer conversion arrived in between.

Top module: `rb_result_buffer`

## Requirements
- R1: With `align_left`=1, the high byte of a pair reads result bits 9..2 and the low byte reads result bits 1..0 in byte bits 7..6 with zeros below.
- R2: With `align_left`=0, the high byte reads result bits 9..8 in byte bits 1..0 with zeros above, and the low byte reads result bits 7..0.
- R3: Reading the first byte of a pair (high byte when left-aligned, low byte when right-aligned) freezes the partner byte. The next read of that partner in the same pair returns the frozen value even if conversions occurred in between.
- R4: A partner-byte read that is not preceded by a first-byte read of the same pair, or that follows an already consumed snapshot, returns the live value.
- R5: With `buf_en`=0, `eoc` is high for exactly the one cycle after each accepted conversion.
- R6: With `buf_en`=1, results go to slots 0,1,..,`last_slot` and then wrap to 0. Slot k is read at byte address 2+2k (high) and 3+2k (low), and addresses 0 (high) and 1 (low) always read the latest result.
- R7: With `buf_en`=1, `eoc` pulses for one cycle only after the conversion that fills slot `last_slot`.
- R8: A rising edge of `buf_en` returns the write position to slot 0.
- R9: A write into a slot whose unread bit is set sets `ovr`. The unread bit is set by a write and cleared by the partner (second) byte read of that slot.
- R10: `ovr` stays set until `ovr_wr`=1 with `ovr_wdata`=0. Writing 1 has no effect, and a new overrun in the same cycle as a clear wins.
- R11: After reset `rd_data`, `eoc` and `ovr` are 0, and `rd_data` holds its value in cycles without `rd_en`.
- R12: A read at an address above the last slot's low byte returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | A conversion result is present this cycle |
| conv_data | input | 10 | Conversion result |
| align_left | input | 1 | 1 = left alignment, 0 = right alignment |
| buf_en | input | 1 | Enables ring-buffered storage |
| last_slot | input | SW | Index of the last slot used in the ring |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Byte address; bit 0 = 1 selects the low byte |
| ovr_wr | input | 1 | Write strobe for the overrun flag |
| ovr_wdata | input | 1 | Value written; only 0 acts (clears) |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| eoc | output | 1 | End-of-conversion pulse |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The bench aims at the snapshot path. It reads the first byte, lets a fresh conversion land, and then reads the partner in both alignments. A design that latched the wrong byte, or chose the first byte regardless of alignment, returns the new result's byte there. A second partner read must then fall back to the live value, which catches a shadow that never expires.

In ring mode the bench checks that `eoc` stays low until the last slot fills. It checks that a slot drained by its partner read accepts a rewrite silently, while an undrained one sets `ovr`. It also checks that an overrun arriving together with a clear keeps the flag set and that re-enabling buffering sends the next result to slot 0. Get any of these wrong and the slot contents or flag read back differently.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;

  typedef logic [RES_W-1:0]  raw_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Byte of a 10-bit result as seen at one half of a 16-bit pair.
  function automatic byte_t fmt_byte(raw_t d, logic left, logic low);
    byte_t b;
    if (left) begin
      b = low ? {d[1:0], 6'b000000} : d[9:2];
    end else begin
      b = low ? d[7:0] : {6'b000000, d[9:8]};
    end
    return b;
  endfunction

  // Which half of a pair must be read first under a given alignment.
  function automatic logic is_first_half(logic left, logic low);
    return left ? !low : low;
  endfunction

endpackage

// File: rtl/rb_slot_ring.sv
module rb_slot_ring
  import rb_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_en,
  input  logic [SW-1:0]    last_slot,
  input  logic             wr_vld,
  input  raw_t             wr_data,
  input  logic             clr_vld,
  input  logic [SW-1:0]    clr_idx,
  input  logic [SW-1:0]    rd_idx,
  output raw_t             rd_raw,
  output logic [NSLOT-1:0] slot_we,
  output logic             ovr_hit,
  output logic             full_evt
);

  localparam logic [SW-1:0] TOP_IDX = SW'(NSLOT - 1);

  raw_t             slot_q [NSLOT];
  logic [NSLOT-1:0] unread_q;
  logic [SW-1:0]    wptr_q;
  logic             buf_en_q;
  logic             en_rise;
  logic [SW-1:0]    ptr_eff;
  logic             we;
  logic             clr_same;

  assign en_rise  = buf_en & ~buf_en_q;
  assign ptr_eff  = en_rise ? '0 : wptr_q;
  assign we       = wr_vld & buf_en;
  assign clr_same = clr_vld && (clr_idx == ptr_eff);
  assign ovr_hit  = we && unread_q[ptr_eff] && !clr_same;
  assign full_evt = we && ((ptr_eff == last_slot) || (ptr_eff == TOP_IDX));
  assign rd_raw   = slot_q[rd_idx];

  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      slot_we[k] = we && (ptr_eff == SW'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en_q <= 1'b0;
      wptr_q   <= '0;
    end else begin
      buf_en_q <= buf_en;
      if (we) begin
        wptr_q <= full_evt ? '0 : ptr_eff + SW'(1);
      end else if (en_rise) begin
        wptr_q <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unread_q <= '0;
      for (int k = 0; k < NSLOT; k++) slot_q[k] <= '0;
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        if (slot_we[k]) begin
          slot_q[k]   <= wr_data;
          unread_q[k] <= 1'b1;
        end else if (clr_vld && (clr_idx == SW'(k))) begin
          unread_q[k] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/rb_read_port.sv
module rb_read_port
  import rb_pkg::*;
#(
  parameter int PW = 4,
  localparam int AW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          align_left,
  input  raw_t          live_raw,
  input  logic          pair_ok,
  output logic [PW-1:0] pair_idx,
  output logic          second_rd,
  output byte_t         rd_data
);

  logic          is_low;
  logic          first;
  logic          first_rd;
  byte_t         live_byte;
  byte_t         other_byte;
  byte_t         shd_q;
  logic          shd_vld_q;
  logic [PW-1:0] shd_pair_q;
  logic          shd_hit;

  assign pair_idx   = rd_addr[AW-1:1];
  assign is_low     = rd_addr[0];
  assign first      = is_first_half(align_left, is_low);
  assign first_rd   = rd_en & first;
  assign second_rd  = rd_en & ~first;
  assign live_byte  = pair_ok ? fmt_byte(live_raw, align_left, is_low)  : '0;
  assign other_byte = pair_ok ? fmt_byte(live_raw, align_left, !is_low) : '0;
  assign shd_hit    = shd_vld_q && (shd_pair_q == pair_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      shd_q      <= '0;
      shd_vld_q  <= 1'b0;
      shd_pair_q <= '0;
    end else if (first_rd) begin
      rd_data    <= live_byte;
      shd_q      <= other_byte;
      shd_vld_q  <= 1'b1;
      shd_pair_q <= pair_idx;
    end else if (second_rd) begin
      rd_data    <= shd_hit ? shd_q : live_byte;
      shd_vld_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/rb_event_gen.sv
module rb_event_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_valid,
  input  logic buf_en,
  input  logic full_evt,
  input  logic ovr_hit,
  input  logic ovr_wr,
  input  logic ovr_wdata,
  output logic eoc,
  output logic ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc <= 1'b0;
      ovr <= 1'b0;
    end else begin
      eoc <= buf_en ? full_evt : conv_valid;
      if (ovr_hit)                   ovr <= 1'b1;
      else if (ovr_wr && !ovr_wdata) ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/rb_result_buffer.sv
module rb_result_buffer
  import rb_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int PW = $clog2(NSLOT + 1),
  localparam int AW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_valid,
  input  logic [9:0]    conv_data,
  input  logic          align_left,
  input  logic          buf_en,
  input  logic [SW-1:0] last_slot,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          ovr_wr,
  input  logic          ovr_wdata,
  output logic [7:0]    rd_data,
  output logic          eoc,
  output logic          ovr
);

  raw_t             main_q;
  raw_t             ring_raw;
  raw_t             live_raw;
  logic [PW-1:0]    pair_idx;
  logic [PW-1:0]    slot_sel;
  logic             pair_ok;
  logic             second_rd;
  logic             clr_vld;
  logic [SW-1:0]    clr_idx;
  logic [NSLOT-1:0] slot_we;
  logic             ovr_hit;
  logic             full_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          main_q <= '0;
    else if (conv_valid) main_q <= conv_data;
  end

  assign slot_sel = pair_idx - PW'(1);
  assign pair_ok  = (32'(pair_idx) <= NSLOT);
  assign live_raw = (pair_idx == '0) ? main_q : ring_raw;
  assign clr_vld  = second_rd && pair_ok && (pair_idx != '0);
  assign clr_idx  = SW'(slot_sel);

  rb_slot_ring #(.NSLOT(NSLOT)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_en    (buf_en),
    .last_slot (last_slot),
    .wr_vld    (conv_valid),
    .wr_data   (conv_data),
    .clr_vld   (clr_vld),
    .clr_idx   (clr_idx),
    .rd_idx    (SW'(slot_sel)),
    .rd_raw    (ring_raw),
    .slot_we   (slot_we),
    .ovr_hit   (ovr_hit),
    .full_evt  (full_evt)
  );

  rb_read_port #(.PW(PW)) rdp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .align_left (align_left),
    .live_raw   (live_raw),
    .pair_ok    (pair_ok),
    .pair_idx   (pair_idx),
    .second_rd  (second_rd),
    .rd_data    (rd_data)
  );

  rb_event_gen evt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .buf_en     (buf_en),
    .full_evt   (full_evt),
    .ovr_hit    (ovr_hit),
    .ovr_wr     (ovr_wr),
    .ovr_wdata  (ovr_wdata),
    .eoc        (eoc),
    .ovr        (ovr)
  );

endmodule

// File: rtl/rb_result_buffer_chk.sv
module rb_result_buffer_chk #(
  parameter int NSLOT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_valid,
  input logic             buf_en,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic             ovr_wr,
  input logic             ovr_wdata,
  input logic             eoc,
  input logic             ovr,
  input logic [NSLOT-1:0] slot_we,
  input logic             ovr_hit
);

  // R5
  eoc_unbuf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid && !buf_en |=> eoc);

  // R7
  eoc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(conv_valid));

  // R6
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));

  // R9
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ovr_hit));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !(ovr_wr && !ovr_wdata) |=> ovr);

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_wr && !ovr_wdata && !ovr_hit |=> !ovr);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind rb_result_buffer rb_result_buffer_chk #(.NSLOT(NSLOT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_valid (conv_valid),
  .buf_en     (buf_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .ovr_wr     (ovr_wr),
  .ovr_wdata  (ovr_wdata),
  .eoc        (eoc),
  .ovr        (ovr),
  .slot_we    (slot_we),
  .ovr_hit    (ovr_hit)
);

// File: tb/rb_result_buffer_tb_top.sv
module rb_result_buffer_tb_top;

  localparam int NSLOT = 8;
  localparam int SW = $clog2(NSLOT);
  localparam int AW = $clog2(NSLOT + 1) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_valid = 1'b0;
  logic [9:0]    conv_data = '0;
  logic          align_left = 1'b1;
  logic          buf_en = 1'b0;
  logic [SW-1:0] last_slot = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          ovr_wr = 1'b0;
  logic          ovr_wdata = 1'b0;
  logic [7:0]    rd_data;
  logic          eoc;
  logic          ovr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rb_result_buffer #(.NSLOT(NSLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
    .align_left(align_left), .buf_en(buf_en), .last_slot(last_slot),
    .rd_en(rd_en), .rd_addr(rd_addr), .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .rd_data(rd_data), .eoc(eoc), .ovr(ovr)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one read, expected byte goes to the scoreboard.
  task automatic rd(input int addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = AW'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // One conversion; returns at the negedge where eoc reflects it.
  task automatic conv(input logic [9:0] d, input logic clr);
    @(negedge clk);
    conv_valid = 1'b1;
    conv_data  = d;
    ovr_wr     = clr;
    ovr_wdata  = 1'b0;
    @(negedge clk);
    conv_valid = 1'b0;
    ovr_wr     = 1'b0;
  endtask

  task automatic wr_ovr(input logic v);
    @(negedge clk);
    ovr_wr    = 1'b1;
    ovr_wdata = v;
    @(negedge clk);
    ovr_wr = 1'b0;
  endtask

  // Monitor: compares each read result against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: actual %h expected none", rd_data);
        end else begin
          check(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({7'd0, eoc}, 8'h00, "R11 eoc reset");
    check({7'd0, ovr}, 8'h00, "R11 ovr reset");
    check(rd_data, 8'h00, "R11 rd_data reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Unbuffered, left aligned
    align_left = 1'b1;
    conv(10'h2B5, 1'b0);
    check({7'd0, eoc}, 8'h01, "R5 eoc after conversion");
    @(negedge clk);
    check({7'd0, eoc}, 8'h00, "R5 eoc single cycle");
    rd(0, 8'hAD, "R1 left high byte");
    rd(1, 8'h40, "R1 left low byte");

    // R3 shadow, left: high first then new conversion
    conv(10'h3C7, 1'b0);
    rd(0, 8'hF1, "R3 left first byte");
    conv(10'h001, 1'b0);
    rd(1, 8'hC0, "R3 left partner from snapshot");
    rd(1, 8'h40, "R4 left partner live after snapshot used");

    // Right aligned
    align_left = 1'b0;
    conv(10'h2B5, 1'b0);
    rd(1, 8'hB5, "R2 right low byte");
    rd(0, 8'h02, "R2 right high byte");
    conv(10'h17E, 1'b0);
    rd(1, 8'h7E, "R3 right first byte");
    conv(10'h2FF, 1'b0);
    rd(0, 8'h01, "R3 right partner from snapshot");
    rd(0, 8'h02, "R4 right partner live");
    repeat (4) @(negedge clk);
    check(rd_data, 8'h02, "R11 rd_data held without read");

    // Buffered ring of four slots
    last_slot = SW'(3);
    @(negedge clk);
    buf_en = 1'b1;
    @(negedge clk);
    conv(10'h101, 1'b0); check({7'd0, eoc}, 8'h00, "R7 no eoc slot0");
    conv(10'h102, 1'b0); check({7'd0, eoc}, 8'h00, "R7 no eoc slot1");
    conv(10'h103, 1'b0); check({7'd0, eoc}, 8'h00, "R7 no eoc slot2");
    conv(10'h104, 1'b0); check({7'd0, eoc}, 8'h01, "R7 eoc on last slot");
    rd(3, 8'h01, "R6 slot0 low");
    rd(2, 8'h01, "R6 slot0 high");
    rd(5, 8'h02, "R6 slot1 low");
    rd(4, 8'h01, "R6 slot1 high");
    rd(1, 8'h04, "R6 main register latest");
    check({7'd0, ovr}, 8'h00, "R9 no overrun yet");
    conv(10'h105, 1'b0);
    check({7'd0, ovr}, 8'h00, "R9 drained slot0 rewritten");
    conv(10'h106, 1'b0);
    check({7'd0, ovr}, 8'h00, "R9 drained slot1 rewritten");
    conv(10'h107, 1'b0);
    check({7'd0, ovr}, 8'h01, "R9 overrun on unread slot2");
    conv(10'h108, 1'b0);
    check({7'd0, eoc}, 8'h01, "R7 eoc second round");

    // R10 flag write behaviour
    wr_ovr(1'b1);
    check({7'd0, ovr}, 8'h01, "R10 write one ignored");
    wr_ovr(1'b0);
    check({7'd0, ovr}, 8'h00, "R10 write zero clears");
    repeat (2) @(negedge clk);
    check({7'd0, ovr}, 8'h00, "R10 stays clear");
    conv(10'h109, 1'b1);
    check({7'd0, ovr}, 8'h01, "R10 overrun beats clear");
    wr_ovr(1'b0);

    // R8 re-enable restarts at slot 0
    buf_en = 1'b0;
    repeat (2) @(negedge clk);
    buf_en = 1'b1;
    repeat (2) @(negedge clk);
    conv(10'h1AA, 1'b0);
    check({7'd0, eoc}, 8'h00, "R8 first write not last slot");
    check({7'd0, ovr}, 8'h01, "R9 overrun on slot0 after restart");
    rd(3, 8'hAA, "R8 slot0 low after restart");
    rd(2, 8'h01, "R8 slot0 high after restart");

    align_left = 1'b1;
    rd(4, 8'h41, "R6 slot1 left high");
    rd(5, 8'h80, "R6 slot1 left low");

    rd(20, 8'h00, "R12 address beyond slots high");
    rd(21, 8'h00, "R12 address beyond slots low");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule